// File: doc/BRIEF.md
# Pipelined Memory-to-Memory Add/Subtract Core

This block is a minimal programmable arithmetic core. Its instruction set holds two operations, add and subtract, and every instruction names three data-memory locations: two sources and one destination. Constants cannot be loaded and there is no register file. Both operands come from data memory and the result goes back to data memory.

Each instruction moves through five stages in a fixed order. The stages are fetch, read of the first source, read of the second source, arithmetic, and write of the destination. A new instruction may enter on every cycle, so up to five instructions are in flight at once. The surrounding memory system therefore serves, in one cycle, an instruction fetch, two data reads belonging to different instructions and one data write.

Because operands live in memory, a source read can overlap an older instruction that has not yet stored its result. The core compares addresses and forwards the newest in-flight value, so a program gives the same results it would give if each instruction ran to completion before the next one started. A halt input stops fetching. Instructions already in flight finish normally, and each completed write is reported on a retire port and counted.

Top module: `mcalc_core`

## Requirements
- R1: While rst_n is low at a clock edge, the core is reset. After release, imem_addr is 0, retire_valid is 0 and retire_count is 0.
- R2: An instruction word is 1+3*AW bits wide. The top bit is the opcode (0 = add, 1 = subtract). Below it sit the first source address, then the second source address, then the destination address in the low AW bits.
- R3: Add stores (src1 + src2) mod 2^DW in the destination, for example 0xFFFF + 0x0002 = 0x0001.
- R4: Subtract stores (src1 - src2) mod 2^DW in the destination, for example 0x0000 - 0x0001 = 0xFFFF.
- R5: The instruction address is issued in cycle k. Its read data returns in cycle k+1 from a one-cycle synchronous instruction memory. The destination write, with retire_valid high, occurs in cycle k+4.
- R6: A run of back-to-back fetches retires one instruction on every cycle, with no gaps.
- R7: A first-source read returns the value left by all older instructions, even when the producer is 1, 2, 3 or 4 instructions older.
- R8: A second-source read returns the value left by all older instructions, including the case where the same address is used as both sources and the destination.
- R9: While halt is high, no instruction is fetched and imem_addr holds its value. Instructions already in flight still complete, and fetch resumes at the next address.
- R10: retire_count increases by exactly one for each cycle in which retire_valid is high, and stays the same otherwise.
- R11: The retire port reports the destination address and value of each write, and the sequence of retired writes matches in-order sequential execution of the program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| halt | input | 1 | Stops instruction fetch while high |
| imem_addr | output | IA_W | Instruction memory read address |
| imem_rdata | input | 1+3*AW | Instruction word, one cycle after its address |
| dmem_ra_addr | output | AW | First-source read address |
| dmem_ra_data | input | DW | First-source read data, same cycle |
| dmem_rb_addr | output | AW | Second-source read address |
| dmem_rb_data | input | DW | Second-source read data, same cycle |
| dmem_we | output | 1 | Data memory write enable |
| dmem_waddr | output | AW | Data memory write address |
| dmem_wdata | output | DW | Data memory write data |
| retire_valid | output | 1 | An instruction completes this cycle |
| retire_addr | output | AW | Destination address of the retiring instruction |
| retire_data | output | DW | Value written by the retiring instruction |
| retire_count | output | CNT_W | Number of instructions retired since reset |

## Verification
The bench builds the core with its defaults: 8-bit addresses, 16-bit data, an 8-bit instruction address and a 16-bit retirement counter. At 16 bits, the wrap cases 0xFFFF+2 and 0-1 can be reached directly. A program of about a hundred instructions fits in the 256-word instruction space without the fetch address wrapping. Random instructions confined to sixteen data locations make producer and consumer addresses collide at every forwarding distance, under both back-to-back and gapped halt patterns.

// File: rtl/mcalc_pkg.sv
// Shared types for the memory-to-memory arithmetic core.
// Assumes: one opcode bit selects between add and subtract.
package mcalc_pkg;
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } mc_op_e;
endpackage

// File: rtl/mcalc_fetch.sv
// Fetch stage: holds the instruction address and marks which cycles issue a fetch.
// Assumes: the instruction memory returns data one cycle after the address.
module mcalc_fetch #(
    parameter int IA_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            halt,
    output logic [IA_W-1:0] pc,
    output logic            fetched_v
);
    // Advance the address and flag an arriving word whenever fetch is allowed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc        <= '0;
            fetched_v <= 1'b0;
        end else begin
            fetched_v <= !halt;
            if (!halt) pc <= pc + 1'b1;
        end
    end

    // R1: the first cycle after reset starts at address 0 with nothing arriving
    a_r1_fetch_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pc == '0 && !fetched_v));

    // R9: a halted cycle leaves the address untouched and brings no word
    a_r9_halt_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> ($stable(pc) && !fetched_v));
endmodule

// File: rtl/mcalc_fwd.sv
// Operand select: returns the newest value of an address among two in-flight
// producers and the memory read data.
// Assumes: the "young" producer is newer than the "old" one; both are newer than memory.
module mcalc_fwd #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] mem_data,
    input  logic          yng_v,
    input  logic [AW-1:0] yng_addr,
    input  logic [DW-1:0] yng_data,
    input  logic          old_v,
    input  logic [AW-1:0] old_addr,
    input  logic [DW-1:0] old_data,
    output logic [DW-1:0] rd_data
);
    // Pick the youngest matching producer, falling back to memory.
    always_comb begin
        if (yng_v && (yng_addr == rd_addr))      rd_data = yng_data;
        else if (old_v && (old_addr == rd_addr)) rd_data = old_data;
        else                                     rd_data = mem_data;
    end
endmodule

// File: rtl/mcalc_alu.sv
// Arithmetic unit: wrapping add or subtract, no flags.
// Assumes: operands and result share one width.
module mcalc_alu
    import mcalc_pkg::*;
#(
    parameter int DW = 16
) (
    input  mc_op_e        op,
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] y,
    output logic [DW-1:0] res
);
    // Compute the result modulo 2^DW.
    always_comb begin
        case (op)
            OP_SUB:  res = x - y;
            default: res = x + y;
        endcase
    end
endmodule

// File: rtl/mcalc_core.sv
// Five-stage add/subtract core working directly on data memory.
// Stages: fetch, read first source, read second source, compute, write.
// Assumes: data memory reads return data in the same cycle, and a write lands at the
// clock edge that ends the write stage. Hazards are resolved by address forwarding:
// the first source is read one stage before the second, so it is corrected once more
// in the second-source stage from the compute result.
module mcalc_core
    import mcalc_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DW    = 16,
    parameter int IA_W  = 8,
    parameter int CNT_W = 16,
    localparam int IW   = 1 + 3 * AW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt,
    output logic [IA_W-1:0]  imem_addr,
    input  logic [IW-1:0]    imem_rdata,
    output logic [AW-1:0]    dmem_ra_addr,
    input  logic [DW-1:0]    dmem_ra_data,
    output logic [AW-1:0]    dmem_rb_addr,
    input  logic [DW-1:0]    dmem_rb_data,
    output logic             dmem_we,
    output logic [AW-1:0]    dmem_waddr,
    output logic [DW-1:0]    dmem_wdata,
    output logic             retire_valid,
    output logic [AW-1:0]    retire_addr,
    output logic [DW-1:0]    retire_data,
    output logic [CNT_W-1:0] retire_count
);
    // Field positions in the instruction word (R2).
    localparam int OP_BIT = IW - 1;
    localparam int S1_LO  = 2 * AW;
    localparam int S2_LO  = AW;

    logic            fetched_v;
    logic [IA_W-1:0] pc;

    // Decoded fields of the word arriving this cycle (first-source stage).
    mc_op_e  dec_op;
    logic [AW-1:0] dec_s1, dec_s2, dec_dst;

    // Second-source stage registers.
    logic          rb_v;
    mc_op_e        rb_op;
    logic [AW-1:0] rb_s1, rb_s2, rb_dst;
    logic [DW-1:0] rb_x;

    // Compute stage registers.
    logic          ex_v;
    mc_op_e        ex_op;
    logic [AW-1:0] ex_dst;
    logic [DW-1:0] ex_x, ex_y;

    // Write stage registers.
    logic          wr_v;
    logic [AW-1:0] wr_dst;
    logic [DW-1:0] wr_val;

    logic [DW-1:0] ex_res, s1_early, s1_fixed, s2_val;

    mcalc_fetch #(.IA_W(IA_W)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt      (halt),
        .pc        (pc),
        .fetched_v (fetched_v)
    );

    assign imem_addr = pc;

    // Split the incoming word into opcode and address fields.
    always_comb begin
        dec_op  = mc_op_e'(imem_rdata[OP_BIT]);
        dec_s1  = imem_rdata[S1_LO +: AW];
        dec_s2  = imem_rdata[S2_LO +: AW];
        dec_dst = imem_rdata[0 +: AW];
    end

    assign dmem_ra_addr = dec_s1;
    assign dmem_rb_addr = rb_s2;

    mcalc_alu #(.DW(DW)) u_alu (
        .op  (ex_op),
        .x   (ex_x),
        .y   (ex_y),
        .res (ex_res)
    );

    // First source, first look: producers in compute and write stages.
    mcalc_fwd #(.AW(AW), .DW(DW)) u_fwd_s1_early (
        .rd_addr  (dec_s1),
        .mem_data (dmem_ra_data),
        .yng_v    (ex_v),
        .yng_addr (ex_dst),
        .yng_data (ex_res),
        .old_v    (wr_v),
        .old_addr (wr_dst),
        .old_data (wr_val),
        .rd_data  (s1_early)
    );

    // First source, correction: the producer that was one stage ahead now computes.
    mcalc_fwd #(.AW(AW), .DW(DW)) u_fwd_s1_fix (
        .rd_addr  (rb_s1),
        .mem_data (rb_x),
        .yng_v    (ex_v),
        .yng_addr (ex_dst),
        .yng_data (ex_res),
        .old_v    (1'b0),
        .old_addr ('0),
        .old_data ('0),
        .rd_data  (s1_fixed)
    );

    // Second source: producers in compute and write stages.
    mcalc_fwd #(.AW(AW), .DW(DW)) u_fwd_s2 (
        .rd_addr  (rb_s2),
        .mem_data (dmem_rb_data),
        .yng_v    (ex_v),
        .yng_addr (ex_dst),
        .yng_data (ex_res),
        .old_v    (wr_v),
        .old_addr (wr_dst),
        .old_data (wr_val),
        .rd_data  (s2_val)
    );

    // Move instructions one stage forward each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rb_v   <= 1'b0;
            rb_op  <= OP_ADD;
            rb_s1  <= '0;
            rb_s2  <= '0;
            rb_dst <= '0;
            rb_x   <= '0;
            ex_v   <= 1'b0;
            ex_op  <= OP_ADD;
            ex_dst <= '0;
            ex_x   <= '0;
            ex_y   <= '0;
            wr_v   <= 1'b0;
            wr_dst <= '0;
            wr_val <= '0;
        end else begin
            rb_v   <= fetched_v;
            rb_op  <= dec_op;
            rb_s1  <= dec_s1;
            rb_s2  <= dec_s2;
            rb_dst <= dec_dst;
            rb_x   <= s1_early;
            ex_v   <= rb_v;
            ex_op  <= rb_op;
            ex_dst <= rb_dst;
            ex_x   <= s1_fixed;
            ex_y   <= s2_val;
            wr_v   <= ex_v;
            wr_dst <= ex_dst;
            wr_val <= ex_res;
        end
    end

    assign dmem_we      = wr_v;
    assign dmem_waddr   = wr_dst;
    assign dmem_wdata   = wr_val;
    assign retire_valid = wr_v;
    assign retire_addr  = wr_dst;
    assign retire_data  = wr_val;

    // Count completed writes.
    always_ff @(posedge clk) begin
        if (!rst_n)    retire_count <= '0;
        else if (wr_v) retire_count <= retire_count + 1'b1;
    end

    // R1: nothing retires and the count is clear right after reset
    a_r1_core_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!retire_valid && retire_count == '0));

    // R5: an arriving word retires three cycles later
    a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
        fetched_v |-> ##3 retire_valid);

    // R10: each retirement adds one to the count
    a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        retire_valid |=> (retire_count == CNT_W'($past(retire_count) + 1'b1)));

    // R10: the count holds when nothing retires
    a_r10_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !retire_valid |=> $stable(retire_count));
endmodule

// File: tb/mcalc_core_bench.sv
// Scoreboard bench: a driver pushes the writes a sequential reference model predicts,
// and a monitor pops and compares them as the core retires instructions.
module mcalc_core_bench;
    localparam int AW = 8, DW = 16, IA_W = 8, CNT_W = 16;
    localparam int IW = 1 + 3 * AW;
    localparam int NPROG = 94;

    typedef struct {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        string         tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt = 1'b1;
    logic [IA_W-1:0] imem_addr;
    logic [IW-1:0] imem_rdata;
    logic [AW-1:0] dmem_ra_addr, dmem_rb_addr, dmem_waddr, retire_addr;
    logic [DW-1:0] dmem_ra_data, dmem_rb_data, dmem_wdata, retire_data;
    logic dmem_we, retire_valid;
    logic [CNT_W-1:0] retire_count;

    logic [IW-1:0] im [256];
    logic [DW-1:0] dm [256];
    logic [DW-1:0] rm [256];
    exp_t scb [$];

    int tests = 0, fails = 0;
    int pc_m = 0;
    int run = 0, max_run = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #2ns clk = ~clk;

    mcalc_core #(.AW(AW), .DW(DW), .IA_W(IA_W), .CNT_W(CNT_W)) u_mcalc_core (
        .clk(clk), .rst_n(rst_n), .halt(halt),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_ra_addr(dmem_ra_addr), .dmem_ra_data(dmem_ra_data),
        .dmem_rb_addr(dmem_rb_addr), .dmem_rb_data(dmem_rb_data),
        .dmem_we(dmem_we), .dmem_waddr(dmem_waddr), .dmem_wdata(dmem_wdata),
        .retire_valid(retire_valid), .retire_addr(retire_addr),
        .retire_data(retire_data), .retire_count(retire_count)
    );

    // Memories: synchronous instruction read, same-cycle data reads, write at the edge.
    always @(posedge clk) imem_rdata <= im[imem_addr];
    always @(posedge clk) if (dmem_we) dm[dmem_waddr] <= dmem_wdata;
    assign dmem_ra_data = dm[dmem_ra_addr];
    assign dmem_rb_data = dm[dmem_rb_addr];

    function automatic logic [IW-1:0] enc(logic op, int a, int b, int c);
        return {op, AW'(a), AW'(b), AW'(c)};
    endfunction

    task automatic check(string req, logic ok, longint act, longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endfunction

    // Reference model: run the next instruction sequentially (R2 field layout) and push its write.
    task automatic push_expected();
        logic [IW-1:0] w;
        logic [AW-1:0] a, b, c;
        logic [DW-1:0] r;
        exp_t e;
        w = im[pc_m];
        a = w[2*AW +: AW];
        b = w[AW +: AW];
        c = w[0 +: AW];
        r = w[IW-1] ? rm[a] - rm[b] : rm[a] + rm[b];
        rm[c] = r;
        e.addr = c;
        e.data = r;
        if (pc_m == 0)      e.tag = "R3";
        else if (pc_m == 1) e.tag = "R4";
        else if (pc_m < 7)  e.tag = "R7";
        else if (pc_m < 14) e.tag = "R8";
        else                e.tag = "R11";
        scb.push_back(e);
        pc_m++;
    endtask

    // Driver: fetch n instructions back to back, then hold halt.
    task automatic issue(int n);
        for (int i = 0; i < n; i++) begin
            push_expected();
            halt = 1'b0;
            @(posedge clk);
            @(negedge clk);
        end
        halt = 1'b1;
    endtask

    // Monitor: compare each retirement against the scoreboard and track run length.
    always @(negedge clk) begin
        if (rst_n && retire_valid) begin
            run++;
            if (run > max_run) max_run = run;
            if (scb.size() == 0) begin
                check("R11 unexpected retire", 1'b0, retire_addr, 0);
            end else begin
                exp_t e;
                e = scb.pop_front();
                check({e.tag, " addr"}, retire_addr == e.addr, retire_addr, e.addr);
                check({e.tag, " data"}, retire_data == e.data, retire_data, e.data);
            end
        end else begin
            run = 0;
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements) actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int seen;
        // Program: fixed hazard cases, then random instructions over 16 locations.
        im[0]  = enc(1'b0, 1, 2, 10);    // R3 wrap add
        im[1]  = enc(1'b1, 3, 4, 11);    // R4 wrap subtract
        im[2]  = enc(1'b0, 5, 6, 20);
        im[3]  = enc(1'b0, 20, 7, 21);   // R7 distance 1
        im[4]  = enc(1'b1, 20, 8, 22);   // R7 distance 2
        im[5]  = enc(1'b0, 20, 9, 23);   // R7 distance 3
        im[6]  = enc(1'b0, 20, 20, 24);  // R7 distance 4
        im[7]  = enc(1'b0, 5, 6, 30);
        im[8]  = enc(1'b1, 7, 30, 31);   // R8 distance 1
        im[9]  = enc(1'b0, 8, 30, 32);   // R8 distance 2
        im[10] = enc(1'b0, 9, 30, 33);   // R8 distance 3
        im[11] = enc(1'b0, 30, 30, 30);  // R8 self
        im[12] = enc(1'b0, 30, 30, 30);  // R8 self, back to back
        im[13] = enc(1'b1, 30, 31, 30);
        for (int i = 14; i < 256; i++) begin
            step_lfsr();
            im[i] = enc(lfsr[0], int'(lfsr[7:4]), int'(lfsr[11:8]), int'(lfsr[15:12]));
        end
        for (int i = 0; i < 256; i++) begin
            dm[i] = 16'(i * 4099 + 7);
            rm[i] = dm[i];
        end
        dm[1] = 16'hFFFF; rm[1] = 16'hFFFF;
        dm[2] = 16'h0002; rm[2] = 16'h0002;
        dm[3] = 16'h0000; rm[3] = 16'h0000;
        dm[4] = 16'h0001; rm[4] = 16'h0001;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: state after reset
        check("R1 imem_addr", imem_addr == 0, imem_addr, 0);
        check("R1 retire_valid", retire_valid == 1'b0, retire_valid, 0);
        check("R1 retire_count", retire_count == 0, retire_count, 0);

        // R5: single instruction, retire exactly four cycles after its fetch edge
        push_expected();
        halt = 1'b0;
        @(posedge clk);
        @(negedge clk);
        halt = 1'b1;
        seen = 0;
        for (int c = 1; c <= 6; c++) begin
            if (retire_valid && seen == 0) seen = c;
            if (c < 6) @(negedge clk);
        end
        check("R5 latency", seen == 4, seen, 4);

        issue(1);
        repeat (6) @(negedge clk);

        // R6, R7, R8: twelve dependent instructions back to back
        max_run = 0;
        issue(12);
        repeat (8) @(negedge clk);
        check("R6 back-to-back run", max_run >= 12, max_run, 12);
        check("R10 count after run", retire_count == 14, retire_count, 14);

        // R9: while halted the address holds and nothing retires
        begin
            logic [IA_W-1:0] held;
            held = imem_addr;
            check("R9 resume address", held == 14, held, 14);
            repeat (5) @(negedge clk);
            check("R9 address held", imem_addr == held, imem_addr, held);
            check("R9 nothing retires", retire_valid == 1'b0, retire_valid, 0);
        end

        // R11: random program, first a burst, then gapped by halt
        issue(30);
        for (int i = 0; i < 50; ) begin
            step_lfsr();
            if (lfsr[0]) begin
                halt = 1'b1;
                @(posedge clk);
                @(negedge clk);
            end else begin
                issue(1);
                i++;
            end
        end
        repeat (8) @(negedge clk);
        check("R10 final count", retire_count == NPROG, retire_count, NPROG);
        check("R9 final address", imem_addr == NPROG, imem_addr, NPROG);
        check("R11 scoreboard drained", scb.size() == 0, scb.size(), 0);
        for (int i = 0; i < 16; i++)
            check("R11 memory image", dm[i] == rm[i], dm[i], rm[i]);

        // R1: reset again after activity
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 count cleared", retire_count == 0, retire_count, 0);
        check("R1 address cleared", imem_addr == 0, imem_addr, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule